// File: doc/BRIEF.md
# Double-Buffered Shadow Register Bank

This block is a small register file for configuration values. Each register can be buffered, which means it holds two copies. A bus write lands in the buffer copy. The active copy, which drives the rest of the device, changes only when an update event moves every buffered register from buffer to active in the same clock edge. Software can therefore change several settings one at a time and have them all take effect together.

An update event can come from two places. One is a bus write of 1 to bit 0 of the update-trigger register. That bit is never stored, so it always reads back as zero. The other is a rising edge on an asynchronous external strobe, which is first synchronised into the register clock domain. A readback-select register decides whether reads of buffered registers return the buffer copy or the active copy. Some registers are marked unbuffered by a parameter mask, and they take effect one edge after they are written. The readback-select register is always unbuffered.

Top module: `shadow_bank`

## Requirements
- R1: After reset, every active register output is zero, and every read returns zero whatever the readback select is set to.
- R2: A bus write to a buffered register changes that register's buffer copy at the next clock edge. Its active output does not change until an update event.
- R3: A write to address 5 with bit 0 set to 1 copies every buffered register from buffer to active at that clock edge. A write to address 5 with bit 0 set to 0 copies nothing.
- R4: Address 5 stores nothing. Reading it returns 0, and its active output slice is always 0.
- R5: A rising edge on `extUpdate` passes through a two-flop synchroniser and an edge detector. It causes exactly one update, and the active outputs change at the third rising clock edge after the strobe rises. Holding the strobe high causes no further updates.
- R6: Any number of buffered registers written before an update are all moved into the active copy by that one update.
- R7: Bit 0 of address 4 selects the readback source: 0 selects the buffer copy, 1 selects the active copy. Unbuffered registers read back the same value under either setting.
- R8: An unbuffered register takes effect without any update event. These are the registers whose `BUF_MASK` bit is 0, which by default are addresses 4, 14 and 15. Its active output shows the written value after the next clock edge.
- R9: When a bus write and an update fall on the same clock edge, the active copy receives the buffer contents from before the write. The new value stays in the buffer until the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe, one write per cycle |
| wrAddr | input | ADDR_W | Bus write address |
| wrData | input | DATA_W | Bus write data |
| rdAddr | input | ADDR_W | Bus read address |
| rdData | output | DATA_W | Read data, combinational from rdAddr |
| extUpdate | input | 1 | Asynchronous external update strobe |
| activeRegs | output | 2**ADDR_W*DATA_W | Active copies; register i occupies bits [i*DATA_W +: DATA_W] |

## Verification
The properties assume that `extUpdate` stays high or low for at least two clock cycles, so the synchroniser never misses an edge. They also assume that a bus write and a write-triggered update never need to share a cycle, since the bus carries only one write per cycle. The bench changes every input on the falling clock edge. It holds each external strobe level for many cycles. It creates the write-and-update collision only through an external strobe, timed so that its synchronised edge lands on the same clock edge as a bus write.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;

  // Strobes handed from the control unit to the register datapath
  typedef struct packed {
    logic bufWrite;   // store bus data into a buffered register
    logic actWrite;   // store bus data straight into an unbuffered register
    logic doUpdate;   // copy all buffered registers to their active copies
  } bankStrobes_t;

endpackage

// File: rtl/shadow_bank_ctrl.sv
module shadow_bank_ctrl
  import shadow_bank_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int UPD_ADDR = 5,
  parameter int SYNC_STAGES = 2,
  parameter logic [(1<<ADDR_W)-1:0] EFF_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              updBit,
  input  logic              extUpdate,
  output bankStrobes_t      strb
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   extPulse;
  logic                   isUpdAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], extUpdate};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign extPulse  = syncQ[SYNC_STAGES-1] & ~prevQ;
  assign isUpdAddr = (wrAddr == ADDR_W'(UPD_ADDR));

  always_comb begin
    strb.bufWrite = wrEn && !isUpdAddr && EFF_MASK[wrAddr];
    strb.actWrite = wrEn && !isUpdAddr && !EFF_MASK[wrAddr];
    strb.doUpdate = (wrEn && isUpdAddr && updBit) || extPulse;
  end

endmodule

// File: rtl/shadow_bank_dp.sv
module shadow_bank_dp
  import shadow_bank_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SEL_ADDR = 4,
  parameter int UPD_ADDR = 5,
  parameter logic [(1<<ADDR_W)-1:0] EFF_MASK = '0,
  localparam int NUM_REGS = 1 << ADDR_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bankStrobes_t               strb,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [ADDR_W-1:0]          rdAddr,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_REGS*DATA_W-1:0] activeRegs
);

  logic [NUM_REGS-1:0][DATA_W-1:0] bufArr;
  logic [NUM_REGS-1:0][DATA_W-1:0] actArr;
  logic                            selActive;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == UPD_ADDR) begin : g_trigger
      // Self-clearing trigger: nothing is kept
      assign bufArr[i] = '0;
      assign actArr[i] = '0;
    end else if (EFF_MASK[i]) begin : g_buffered
      logic [DATA_W-1:0] bufQ;
      logic [DATA_W-1:0] actQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          bufQ <= '0;
          actQ <= '0;
        end else begin
          if (strb.bufWrite && wrAddr == ADDR_W'(i)) bufQ <= wrData;
          if (strb.doUpdate) actQ <= bufQ;
        end
      end
      assign bufArr[i] = bufQ;
      assign actArr[i] = actQ;
    end else begin : g_direct
      logic [DATA_W-1:0] regQ;
      always_ff @(posedge clk) begin
        if (!rstN) regQ <= '0;
        else if (strb.actWrite && wrAddr == ADDR_W'(i)) regQ <= wrData;
      end
      assign bufArr[i] = regQ;
      assign actArr[i] = regQ;
    end
    assign activeRegs[i*DATA_W +: DATA_W] = actArr[i];
  end

  assign selActive = actArr[SEL_ADDR][0];

  always_comb begin
    if (selActive || !EFF_MASK[rdAddr]) rdData = actArr[rdAddr];
    else                                rdData = bufArr[rdAddr];
  end

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SEL_ADDR = 4,
  parameter int UPD_ADDR = 5,
  parameter int SYNC_STAGES = 2,
  parameter logic [(1<<ADDR_W)-1:0] BUF_MASK = 16'h3FCF,
  localparam int NUM_REGS = 1 << ADDR_W,
  localparam logic [NUM_REGS-1:0] EFF_MASK =
    BUF_MASK & ~(NUM_REGS'(1) << SEL_ADDR) & ~(NUM_REGS'(1) << UPD_ADDR)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [ADDR_W-1:0]          rdAddr,
  output logic [DATA_W-1:0]          rdData,
  input  logic                       extUpdate,
  output logic [NUM_REGS*DATA_W-1:0] activeRegs
);

  bankStrobes_t strb;

  shadow_bank_ctrl #(
    .ADDR_W(ADDR_W), .UPD_ADDR(UPD_ADDR),
    .SYNC_STAGES(SYNC_STAGES), .EFF_MASK(EFF_MASK)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .updBit(wrData[0]), .extUpdate(extUpdate), .strb(strb)
  );

  shadow_bank_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_ADDR(SEL_ADDR),
    .UPD_ADDR(UPD_ADDR), .EFF_MASK(EFF_MASK)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .activeRegs(activeRegs)
  );

endmodule

// File: rtl/shadow_bank_chk.sv
module shadow_bank_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int UPD_ADDR = 5,
  parameter logic [(1<<ADDR_W)-1:0] EFF_MASK = '0,
  localparam int NUM_REGS = 1 << ADDR_W
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            wrEn,
  input logic [ADDR_W-1:0]               wrAddr,
  input logic [DATA_W-1:0]               wrData,
  input logic [ADDR_W-1:0]               rdAddr,
  input logic [DATA_W-1:0]               rdData,
  input logic [NUM_REGS*DATA_W-1:0]      activeRegs,
  input logic [NUM_REGS-1:0][DATA_W-1:0] bufArr,
  input logic                            doUpdate,
  input logic                            extPulse
);

  // R4
  trigger_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAddr == ADDR_W'(UPD_ADDR) |-> rdData == '0);

  // R5
  single_ext_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    extPulse |=> !extPulse);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    if (i != UPD_ADDR && EFF_MASK[i]) begin : g_buf
      // R3
      update_copies_chk: assert property (@(posedge clk) disable iff (!rstN)
        doUpdate |=> activeRegs[i*DATA_W +: DATA_W] == $past(bufArr[i]));
      // R2
      active_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
        !doUpdate |=> $stable(activeRegs[i*DATA_W +: DATA_W]));
    end else if (i != UPD_ADDR) begin : g_direct
      // R8
      direct_write_chk: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && wrAddr == ADDR_W'(i)) |=>
          activeRegs[i*DATA_W +: DATA_W] == $past(wrData));
    end
  end

endmodule

bind shadow_bank shadow_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UPD_ADDR(UPD_ADDR), .EFF_MASK(EFF_MASK)
) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddr(rdAddr), .rdData(rdData), .activeRegs(activeRegs),
  .bufArr(i_dp.bufArr), .doUpdate(strb.doUpdate), .extPulse(i_ctrl.extPulse)
);

// File: tb/test_shadow_bank.sv
module test_shadow_bank;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int NUM_REGS = 1 << ADDR_W;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_ACT = 2'd2;

  typedef struct packed {
    logic [1:0]        op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] val;   // write data or expected value
  } step_t;

  localparam int NSTEPS = 21;
  localparam step_t STEPS [NSTEPS] = '{
    '{OP_WR,  4'd1,  8'h11},   // R2 buffered write
    '{OP_WR,  4'd2,  8'h22},   // R6 second buffered write
    '{OP_WR,  4'd14, 8'h5A},   // R8 unbuffered write
    '{OP_RD,  4'd1,  8'h11},   // R2 buffer readback
    '{OP_ACT, 4'd1,  8'h00},   // R2 active untouched
    '{OP_ACT, 4'd14, 8'h5A},   // R8 immediate effect
    '{OP_WR,  4'd5,  8'hFE},   // R3 bit0 clear: no update
    '{OP_ACT, 4'd2,  8'h00},   // R3
    '{OP_RD,  4'd5,  8'h00},   // R4
    '{OP_WR,  4'd5,  8'h01},   // R3 trigger
    '{OP_ACT, 4'd1,  8'h11},   // R6
    '{OP_ACT, 4'd2,  8'h22},   // R6
    '{OP_RD,  4'd5,  8'h00},   // R4 self-cleared
    '{OP_WR,  4'd1,  8'h33},   // R7 new buffer value
    '{OP_WR,  4'd4,  8'h01},   // R7 select active
    '{OP_RD,  4'd1,  8'h11},   // R7 active copy
    '{OP_RD,  4'd14, 8'h5A},   // R7 unbuffered same
    '{OP_RD,  4'd4,  8'h01},   // R7 select reads back
    '{OP_WR,  4'd4,  8'h00},   // R7 select buffer
    '{OP_RD,  4'd1,  8'h33},   // R7 buffer copy
    '{OP_ACT, 4'd5,  8'h00}    // R4 trigger slice
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic extUpdate = 1'b0;
  logic [NUM_REGS*DATA_W-1:0] activeRegs;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_bank i_shadow_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .extUpdate(extUpdate),
    .activeRegs(activeRegs)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] actOf(input int a);
    return activeRegs[a*DATA_W +: DATA_W];
  endfunction

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readChk(input string req, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] exp);
    rdAddr = a;
    #1;
    check(req, rdData, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a < NUM_REGS; a++) check("R1 active", actOf(a), 8'h00);
    readChk("R1 read", 4'd3, 8'h00);

    // Vector walk
    for (int s = 0; s < NSTEPS; s++) begin
      case (STEPS[s].op)
        OP_WR:  doWrite(STEPS[s].addr, STEPS[s].val);
        OP_RD:  readChk("R2/R4/R7 read", STEPS[s].addr, STEPS[s].val);
        default: check("R2/R3/R4/R6/R8 active", actOf(int'(STEPS[s].addr)), STEPS[s].val);
      endcase
    end

    // R5 external strobe latency and single update
    doWrite(4'd3, 8'h77);
    extUpdate = 1'b1;
    @(negedge clk); check("R5 edge1", actOf(3), 8'h00);
    @(negedge clk); check("R5 edge2", actOf(3), 8'h00);
    @(negedge clk); check("R5 edge3", actOf(3), 8'h77);
    doWrite(4'd3, 8'h99);
    repeat (6) @(negedge clk);
    check("R5 held high", actOf(3), 8'h77);
    extUpdate = 1'b0;
    repeat (4) @(negedge clk);

    // R9 write and update on the same edge
    doWrite(4'd6, 8'h10);
    extUpdate = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd6; wrData = 8'h20;
    @(negedge clk);
    wrEn = 1'b0;
    check("R9 active old", actOf(6), 8'h10);
    readChk("R9 buffer new", 4'd6, 8'h20);
    check("R9 other reg", actOf(3), 8'h99);
    extUpdate = 1'b0;
    doWrite(4'd5, 8'h01);
    check("R9 next update", actOf(6), 8'h20);

    // R1 reset mid-run
    doWrite(4'd4, 8'h01);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int a = 0; a < NUM_REGS; a++) check("R1 reset again", actOf(a), 8'h00);
    readChk("R1 buffer cleared", 4'd6, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule